// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a memory-mapped MDIO master for the management link to an Ethernet PHY. Software writes one 32-bit command word that already holds a complete management frame, from MSB to LSB: start `01`, a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, turnaround `10` and 16 data bits. The engine first sends a preamble of ones on the MDIO pin, then shifts the word out MSB first, with MDC divided down from the system clock.

For a read, the engine releases the MDIO pin for the turnaround and for the data field. It samples the 16 bits the PHY returns and writes them into bits [15:0] of the same command register, so software reads the result from the word it wrote. A port-enable bit in a separate control register must be set before any command is accepted. A busy flag in that register shows when a frame is in flight. Because the register address field is 5 bits wide, a frame reaches only registers 0x00 to 0x1F directly.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, busy is 0, the control and command registers read as zero, MDC is low and the MDIO output enable is low.
- R2: In the control register (word index CTRL_IDX), bit 4 is the stored management-port enable and bit 0 reads back busy. All other bits read as zero and are not stored.
- R3: A command write while the enable bit is clear is dropped. The command register keeps its old value and no frame starts.
- R4: A command write (word index CMD_IDX) while enabled and idle starts a frame and sets busy. Busy stays high for exactly 2*DIV_HALF*(PRE_LEN+32) clocks.
- R5: On successive MDC rising edges the line carries PRE_LEN ones, then bits 31 down to 0 of the command word.
- R6: MDIO output changes only when MDC falls. Input data is sampled on MDC rising edges.
- R7: A read (opcode bits [29:28] = 10) releases the output enable for the two turnaround bits and the 16 data bits. The sampled data lands in bits [15:0], and bits [31:16] keep their written value.
- R8: A write (opcode bits [29:28] = 01) keeps the output enable high for every bit of the frame, and the register keeps the written word.
- R9: A command write while busy is set is ignored and does not disturb the frame in flight.
- R10: A read from an address where no PHY answers, so the line floats high, returns 0xFFFF in bits [15:0].
- R11: While busy, MDC has a period of 2*DIV_HALF clocks. While idle, MDC stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| busy | output | 1 | Frame in flight |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low = released) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume that the bus signals and mdio_i are known from the first clock after reset. They also assume that software only writes opcodes 01 or 10, so the output-enable pattern follows from the opcode. The bench drives every register write for exactly one clock at a falling system-clock edge. It changes mdio_i only just after an MDC rising edge, which keeps the data stable at the next sample. The sweep covers all 32 PHY addresses with alternating reads and writes, includes absent PHYs, and forces two command writes into frames already in flight.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_W = 32;
   localparam int DATA_W  = 16;
   localparam int TA_POS  = 14;   // frame bit offset (from MSB) of turnaround
   localparam int DAT_POS = 16;   // frame bit offset (from MSB) of data field

   typedef enum logic [1:0] {
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10
   } mdio_op_e;

   function automatic logic is_read_op(input logic [FRAME_W-1:0] w);
      return w[29:28] == OP_READ;
   endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   logic tick;
   logic mdc_q;

   generate
      if (DIV_HALF == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int CW = $clog2(DIV_HALF);
         logic [CW-1:0] hcnt_q;
         assign tick = run && (hcnt_q == CW'(DIV_HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hcnt_q <= '0;
            else if (!run) hcnt_q <= '0;
            else if (tick) hcnt_q <= '0;
            else           hcnt_q <= hcnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mdc_q <= 1'b0;
      else if (!run) mdc_q <= 1'b0;
      else if (tick) mdc_q <= ~mdc_q;
   end

   assign mdc      = mdc_q;
   assign rise_stb = tick && !mdc_q;
   assign fall_stb = tick && mdc_q;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] cmd_in,
   input  logic               rise_stb,
   input  logic               fall_stb,
   input  logic               mdio_i,
   output logic               busy,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic [FRAME_W-1:0] frame
);
   localparam int TOT   = PRE_LEN + FRAME_W;
   localparam int IDX_W = $clog2(TOT + 1);

   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   rel;
   logic [4:0]         pos5;
   logic [FRAME_W-1:0] frame_q;
   logic               busy_q;
   logic               in_pre;
   logic               rd_op;
   logic               hiz;
   logic               cap;
   logic               last;

   generate
      if (PRE_LEN > 0) begin : g_pre
         assign in_pre = idx_q < IDX_W'(PRE_LEN);
      end else begin : g_nopre
         assign in_pre = 1'b0;
      end
   endgenerate

   assign rel   = idx_q - IDX_W'(PRE_LEN);
   assign pos5  = 5'd31 - rel[4:0];
   assign rd_op = is_read_op(frame_q);
   assign hiz   = rd_op && !in_pre && (rel[4:0] >= 5'(TA_POS));
   assign cap   = rd_op && !in_pre && (rel[4:0] >= 5'(DAT_POS));
   assign last  = idx_q == IDX_W'(TOT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         busy_q  <= 1'b0;
         idx_q   <= '0;
      end else if (start) begin
         frame_q <= cmd_in;
         busy_q  <= 1'b1;
         idx_q   <= '0;
      end else if (busy_q) begin
         if (rise_stb && cap) frame_q[pos5] <= mdio_i;
         if (fall_stb) begin
            if (last) busy_q <= 1'b0;
            else      idx_q  <= idx_q + 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign mdio_oe = busy_q && !hiz;
   assign mdio_o  = !busy_q || in_pre || hiz || frame_q[pos5];
   assign frame   = frame_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int CTRL_IDX = 0,
   parameter int CMD_IDX  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [FRAME_W-1:0] bus_wdata,
   input  logic               busy,
   input  logic [FRAME_W-1:0] frame,
   output logic               en,
   output logic               start,
   output logic [FRAME_W-1:0] bus_rdata
);
   localparam int EN_BIT   = 4;
   localparam int BUSY_BIT = 0;

   logic en_q;
   logic sel_ctrl;
   logic sel_cmd;

   assign sel_ctrl = bus_addr == ADDR_W'(CTRL_IDX);
   assign sel_cmd  = bus_addr == ADDR_W'(CMD_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                en_q <= 1'b0;
      else if (bus_wr && sel_ctrl) en_q <= bus_wdata[EN_BIT];
   end

   assign start = bus_wr && sel_cmd && en_q && !busy;
   assign en    = en_q;

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl) begin
         bus_rdata[EN_BIT]   = en_q;
         bus_rdata[BUSY_BIT] = busy;
      end else if (sel_cmd) begin
         bus_rdata = frame;
      end
   end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
   parameter int DIV_HALF = 4,
   parameter int PRE_LEN  = 32,
   parameter int ADDR_W   = 4,
   parameter int CTRL_IDX = 0,
   parameter int CMD_IDX  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              busy,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (PRE_LEN < 0 || PRE_LEN > 64) begin : g_bad_pre
         $error("PRE_LEN must lie in 0..64");
      end
      if (CTRL_IDX == CMD_IDX) begin : g_bad_map
         $error("CTRL_IDX and CMD_IDX must differ");
      end
      if (CTRL_IDX >= (1 << ADDR_W) || CMD_IDX >= (1 << ADDR_W)) begin : g_bad_aw
         $error("register index does not fit ADDR_W");
      end
   endgenerate

   logic        en_q;
   logic        start;
   logic [31:0] frame_q;
   logic        rise_stb;
   logic        fall_stb;

   mdio_regs #(
      .ADDR_W  (ADDR_W),
      .CTRL_IDX(CTRL_IDX),
      .CMD_IDX (CMD_IDX)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .busy     (busy),
      .frame    (frame_q),
      .en       (en_q),
      .start    (start),
      .bus_rdata(bus_rdata)
   );

   mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .mdc     (mdc),
      .rise_stb(rise_stb),
      .fall_stb(fall_stb)
   );

   mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .cmd_in  (bus_wdata),
      .rise_stb(rise_stb),
      .fall_stb(fall_stb),
      .mdio_i  (mdio_i),
      .busy    (busy),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .frame   (frame_q)
   );
endmodule

// File: rtl/mdio_frame_checker.sv
module mdio_frame_checker #(
   parameter int ADDR_W  = 4,
   parameter int CMD_IDX = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              busy,
   input logic              mdc,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic [31:0]       frame,
   input logic              en
);
   logic cmd_wr;
   assign cmd_wr = bus_wr && (bus_addr == ADDR_W'(CMD_IDX));

   assert_start_on_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_wr && en));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> ($past(mdc) && !mdc));

   assert_hold_header_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (frame[31:16] == $past(frame[31:16])));

   assert_disabled_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_wr && !en && !busy) |-> (!busy && frame == $past(frame)));

   assert_write_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame[29:28] == 2'b01) |-> mdio_oe);
endmodule

bind mdio_frame_engine mdio_frame_checker #(
   .ADDR_W (ADDR_W),
   .CMD_IDX(CMD_IDX)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_wr  (bus_wr),
   .bus_addr(bus_addr),
   .busy    (busy),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .frame   (frame_q),
   .en      (en_q)
);

// File: tb/sim_mdio_frame_engine.sv
module sim_mdio_frame_engine;
   localparam int CLK_PERIOD = 10;
   localparam int DH    = 2;
   localparam int PRE   = 32;
   localparam int AW    = 4;
   localparam int CTRL  = 0;
   localparam int CMD   = 1;
   localparam int NBITS = PRE + 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          busy, mdc, mdio_o, mdio_oe, mdio_i;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 0;

   int          mdc_rises = 0;
   int          base = 0;
   int          cyc = 0;
   int          last_rise = 0;
   int          per_err = 0;
   int          edge_err = 0;
   logic [63:0] seen_o, seen_oe;
   bit          phy_on = 0;
   logic [15:0] resp = '0;
   int          rel;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_frame_engine #(
      .DIV_HALF(DH), .PRE_LEN(PRE), .ADDR_W(AW), .CTRL_IDX(CTRL), .CMD_IDX(CMD)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: bit index counts MDC rising edges since the frame began
   assign rel    = mdc_rises - base;
   assign mdio_i = (phy_on && rel >= PRE + 16 && rel < NBITS) ? resp[NBITS-1-rel] : 1'b1;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge mdc) begin
      if (rel >= 0 && rel < 64) begin
         seen_o[rel]  <= mdio_o;
         seen_oe[rel] <= mdio_oe;
      end
      if (rel >= 1 && rel < NBITS && (cyc - last_rise) != 2*DH) per_err <= per_err + 1;
      last_rise <= cyc;
      mdc_rises <= mdc_rises + 1;
   end

   // R6: output may only move together with a falling MDC
   logic p_o = 1'b1, p_mdc = 1'b0, p_busy = 1'b0;
   always @(negedge clk) begin
      if (busy && p_busy && mdio_o != p_o && !(p_mdc && !mdc)) edge_err <= edge_err + 1;
      p_o <= mdio_o; p_mdc <= mdc; p_busy <= busy;
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = AW'(a);
      #1 d = bus_rdata;
   endtask

   task automatic run_frame(input logic [31:0] cmd, input bit present,
                            input logic [15:0] r, input bit intrude, input bit peek);
      int          cnt;
      bit          rd;
      logic [31:0] got, exp;
      int          bad_o, bad_oe;
      phy_on = present; resp = r;
      base = mdc_rises;
      rd = (cmd[29:28] == 2'b10);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(CMD); bus_wdata = cmd;
      @(negedge clk);
      bus_wr = 1'b0;
      cnt = 0;
      while (busy && cnt < 20000) begin
         cnt++;
         if (intrude && cnt == 40) begin
            bus_wr = 1'b1; bus_addr = AW'(CMD); bus_wdata = ~cmd;
         end
         if (intrude && cnt == 41) bus_wr = 1'b0;
         if (peek && cnt == 10) begin
            bus_addr = AW'(CTRL);
            #1 check(bus_rdata == 32'h11, "R2 busy bit", bus_rdata, 32'h11);
         end
         @(negedge clk);
      end
      check(cnt == 2*DH*NBITS, "R4 busy length", cnt, 2*DH*NBITS);
      bad_o = 0; bad_oe = 0;
      for (int i = 0; i < NBITS; i++) begin
         bit eoe, eo;
         eoe = !(rd && i >= PRE + 14);
         eo  = (i < PRE) ? 1'b1 : cmd[NBITS-1-i];
         if (seen_oe[i] != eoe) bad_oe++;
         if (eoe && seen_o[i] != eo) bad_o++;
      end
      check(bad_o == 0, "R5 serial bits", bad_o, 0);
      check(bad_oe == 0, rd ? "R7 release window" : "R8 drive all bits", bad_oe, 0);
      bus_read(CMD, got);
      if (rd) exp = {cmd[31:16], present ? r : 16'hFFFF};
      else    exp = cmd;
      check(got == exp, intrude ? "R9 busy write ignored" :
                        (rd ? (present ? "R7 read data" : "R10 absent PHY") : "R8 write word"),
            got, exp);
      check(!mdc && !mdio_oe && !busy, "R11 idle MDC", {mdc, mdio_oe, busy}, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !mdc && !mdio_oe, "R1 outputs", {busy, mdc, mdio_oe}, 0);
      bus_read(CTRL, d); check(d == 0, "R1 control", d, 0);
      bus_read(CMD, d);  check(d == 0, "R1 command", d, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 command while disabled is dropped
      bus_write(CMD, 32'h5636001F);
      repeat (4) @(negedge clk);
      check(!busy && !mdc, "R3 no frame", {busy, mdc}, 0);
      bus_read(CMD, d); check(d == 0, "R3 register kept", d, 0);

      // R2 enable bit only
      bus_write(CTRL, 32'hFFFF_FFFF);
      bus_read(CTRL, d); check(d == 32'h10, "R2 enable set", d, 32'h10);
      bus_write(CTRL, 32'h0);
      bus_read(CTRL, d); check(d == 0, "R2 enable clear", d, 0);
      bus_write(CTRL, 32'h10);

      // fixed frames
      run_frame(32'h66020000, 1'b1, 16'h1140, 1'b0, 1'b1);
      run_frame(32'h5636001F, 1'b1, 16'h0000, 1'b0, 1'b0);

      // sweep all PHY addresses, alternating read/write
      for (int a = 0; a < 32; a++) begin
         logic [4:0]  ra;
         logic [15:0] wd, rv;
         bit          rd;
         logic [31:0] c;
         ra = 5'((a * 7 + 3) & 31);
         wd = 16'((a * 16'h0811) ^ 16'h5A5A);
         rv = 16'(a * 16'h1357 + 16'h2468);
         rd = (a % 2 == 0);
         c  = {2'b01, rd ? 2'b10 : 2'b01, 5'(a), ra, 2'b10, rd ? 16'h0 : wd};
         run_frame(c, (a % 5) != 0, rv, (a == 3 || a == 4), 1'b0);
      end

      check(per_err == 0, "R11 MDC period", per_err, 0);
      check(edge_err == 0, "R6 drive on fall", edge_err, 0);
      summary();
   end
endmodule